// File: doc/BRIEF.md
# USB Host Control Transfer Sequencer

This block drives one USB control transfer from the host side, through its setup, data and status stages. Software first writes an 8-byte request into four 16-bit request registers and presents a target device address. It then pulses a start input. The block raises its setup-request flag and sends SETUP to an abstracted packet engine. After the setup is acknowledged, it moves through the data stage, if the request length is not zero, and then through the status stage.

The packet engine is a plain request/response pair. The sequencer holds a request with a token, an address, a data toggle and a byte count until the engine returns ACK, NAK, STALL or a timeout. The sequencer keeps track of the data toggle and retries NAKed packets. At high speed it runs PING flow control before OUT data. It reports the outcome through single-cycle interrupt pulses. Packet serialization, CRC and bus timing belong to the engine.

Top module: `usb_ctl_seq`

## Requirements
- R1: A `start_i` pulse while the block is idle sets `busy_o` on the next cycle. `busy_o` stays 1 for the whole setup transaction and clears in the cycle after the setup response is accepted. A `start_i` pulse while a transfer is running is ignored.
- R2: While `busy_o` is 1, writes to the request registers are ignored and `req_regs_o` keeps its value. When the block is not busy, a write with select 0/1/2/3 updates the request-type/request word, value, index or length. `req_regs_o` packs these words as {length, index, value, type/request}, with the request type in bits [7:0].
- R3: Every engine request carries the device address that `dev_sel_i` held at the start pulse.
- R4: The setup transaction uses token code 0 (SETUP), toggle 0 (DATA0) and a byte count of 8. Token codes are: 0 SETUP, 1 IN, 2 OUT, 3 PING. Response codes are: 0 ACK, 1 NAK, 2 STALL, 3 timeout.
- R5: The first packet of the data stage uses toggle 1 (DATA1), and so does the first packet of the status stage. The toggle inverts after each ACKed data packet. A packet that gets NAK or a timeout is repeated with the same toggle.
- R6: Bit 7 of the request type selects the data stage direction (1 = IN). The status stage runs opposite to the data stage. A length of zero skips the data stage, and the status stage is then IN.
- R7: Each OUT data packet carries min(remaining, MAX_PKT) bytes, and an IN request asks for MAX_PKT bytes. The data stage ends when the remaining count reaches zero, or when an IN packet returns fewer than MAX_PKT bytes.
- R8: At high speed, an OUT-direction stage first issues PING and sends OUT data only after a PING ACK. A NAK to OUT data brings PING back. At full speed no PING is issued.
- R9: An ACK to the setup pulses `irq_setup_ack_o`. A NAK or STALL to the setup pulses `irq_setup_err_o` and the block returns to idle.
- R10: A STALL in the data or status stage pulses `irq_stall_o` and the block returns to idle.
- R11: MAX_TMO consecutive timeouts (default 3) pulse `irq_err_o` and return the block to idle. If this happens in the setup stage, `irq_setup_err_o` pulses as well. Any other response resets the timeout count.
- R12: An ACK to the status data packet pulses `irq_done_o` and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Request register write enable |
| reg_sel_i | input | 2 | Register select: 0 type/request, 1 value, 2 index, 3 length |
| reg_wdata_i | input | 16 | Write data |
| req_regs_o | output | 64 | Request registers {length, index, value, type/request} |
| dev_sel_i | input | 7 | Target device address |
| high_speed_i | input | 1 | Bus runs at high speed (enables PING) |
| start_i | input | 1 | Start pulse (sets the setup-request flag) |
| busy_o | output | 1 | Setup-request flag |
| pe_req_valid_o | output | 1 | Engine request pending |
| pe_token_o | output | 2 | Token code |
| pe_addr_o | output | 7 | Device address |
| pe_toggle_o | output | 1 | Data toggle (0 DATA0, 1 DATA1) |
| pe_len_o | output | 16 | Bytes to send or maximum to receive |
| pe_resp_valid_i | input | 1 | Engine response strobe |
| pe_resp_i | input | 2 | Response code |
| pe_rx_len_i | input | 16 | Bytes received on an IN ACK |
| irq_setup_ack_o | output | 1 | Setup acknowledged pulse |
| irq_setup_err_o | output | 1 | Setup failed pulse |
| irq_stall_o | output | 1 | Transfer stalled pulse |
| irq_err_o | output | 1 | Timeout limit pulse |
| irq_done_o | output | 1 | Transfer complete pulse |

## Verification
The transfers tried are:
- a full-speed control read of one short IN packet;
- a high-speed control write of 100 bytes, with NAKs on both PING and OUT;
- a high-speed read, whose status OUT needs PING;
- a no-data request;
- a 128-byte read that ends on an exact multiple of the packet size;
- a read that ends early on a short packet.

The read/write pair separates the direction handling and PING from the toggle rules. The NAK cases separate a retry from a toggle advance. The exact-multiple and short-packet reads separate the two ways the data stage can end. Other runs cover STALL and timeout responses in each stage, a timeout run broken by an ACK, and register writes and start pulses issued while busy.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;

    localparam int LEN_W = 16;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_PING  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_TMO   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_DATA   = 2'd2,
        ST_STATUS = 2'd3
    } stg_e;

    typedef struct packed {
        logic [LEN_W-1:0] wlength;
        logic [LEN_W-1:0] windex;
        logic [LEN_W-1:0] wvalue;
        logic [LEN_W-1:0] rtype;
    } ctl_req_t;

    function automatic logic [LEN_W-1:0] umin(input logic [LEN_W-1:0] a,
                                              input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ctl_req_regs.sv
module ctl_req_regs
    import usbctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [LEN_W-1:0] wdata,
    input  logic             lock,
    output ctl_req_t         req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= '0;
        end else if (we && !lock) begin
            case (sel)
                2'd0: req.rtype   <= wdata;
                2'd1: req.wvalue  <= wdata;
                2'd2: req.windex  <= wdata;
                default: req.wlength <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/ctl_retry_cnt.sv
module ctl_retry_cnt #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic clr,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign hit = inc && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || hit) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
    import usbctl_pkg::*;
#(
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [6:0]       dev_sel,
    input  logic             high_speed,
    input  logic             dir_bit,
    input  logic [LEN_W-1:0] wlength,
    input  logic             resp_valid,
    input  logic [1:0]       resp,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             tmo_hit,
    output logic             accept,
    output logic             is_tmo,
    output logic             in_setup,
    output logic             req_valid,
    output logic [1:0]       token,
    output logic [6:0]       addr,
    output logic             toggle,
    output logic [LEN_W-1:0] len,
    output logic             irq_setup_ack,
    output logic             irq_setup_err,
    output logic             irq_stall,
    output logic             irq_err,
    output logic             irq_done
);
    localparam logic [LEN_W-1:0] MPS = LEN_W'(MAX_PKT);

    stg_e             stage;
    logic             tog_q, ping_q, data_in_q, stat_in_q, hs_q;
    logic [6:0]       addr_q;
    logic [LEN_W-1:0] rem_q;
    logic             out_phase;
    rsp_e             rsp;
    tok_e             tok;
    logic [LEN_W-1:0] out_n, in_n;
    logic             in_last;

    assign rsp       = rsp_e'(resp);
    assign req_valid = (stage != ST_IDLE);
    assign in_setup  = (stage == ST_SETUP);
    assign accept    = req_valid && resp_valid;
    assign is_tmo    = (rsp == RSP_TMO);
    assign addr      = addr_q;
    assign toggle    = tog_q;
    assign out_phase = ((stage == ST_DATA) && !data_in_q) ||
                       ((stage == ST_STATUS) && !stat_in_q);
    assign out_n     = umin(rem_q, MPS);
    assign in_n      = umin(rx_len, rem_q);
    assign in_last   = (rx_len < MPS) || (rx_len >= rem_q);

    always_comb begin
        tok = TOK_SETUP;
        len = '0;
        case (stage)
            ST_SETUP: begin
                tok = TOK_SETUP;
                len = LEN_W'(8);
            end
            ST_DATA: begin
                if (data_in_q) begin
                    tok = TOK_IN;
                    len = MPS;
                end else if (ping_q) begin
                    tok = TOK_PING;
                end else begin
                    tok = TOK_OUT;
                    len = out_n;
                end
            end
            ST_STATUS: begin
                if (stat_in_q)   tok = TOK_IN;
                else if (ping_q) tok = TOK_PING;
                else             tok = TOK_OUT;
            end
            default: ;
        endcase
    end
    assign token = tok;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage         <= ST_IDLE;
            tog_q         <= 1'b0;
            ping_q        <= 1'b0;
            data_in_q     <= 1'b0;
            stat_in_q     <= 1'b0;
            hs_q          <= 1'b0;
            addr_q        <= '0;
            rem_q         <= '0;
            irq_setup_ack <= 1'b0;
            irq_setup_err <= 1'b0;
            irq_stall     <= 1'b0;
            irq_err       <= 1'b0;
            irq_done      <= 1'b0;
        end else begin
            irq_setup_ack <= 1'b0;
            irq_setup_err <= 1'b0;
            irq_stall     <= 1'b0;
            irq_err       <= 1'b0;
            irq_done      <= 1'b0;
            if (stage == ST_IDLE) begin
                if (start) begin
                    stage  <= ST_SETUP;
                    tog_q  <= 1'b0;
                    ping_q <= 1'b0;
                    addr_q <= dev_sel;
                    hs_q   <= high_speed;
                end
            end else if (accept) begin
                if (is_tmo) begin
                    if (tmo_hit) begin
                        irq_err       <= 1'b1;
                        irq_setup_err <= in_setup;
                        stage         <= ST_IDLE;
                    end
                end else if (stage == ST_SETUP) begin
                    if (rsp == RSP_ACK) begin
                        irq_setup_ack <= 1'b1;
                        tog_q         <= 1'b1;
                        rem_q         <= wlength;
                        if (wlength == '0) begin
                            stage     <= ST_STATUS;
                            stat_in_q <= 1'b1;
                            ping_q    <= 1'b0;
                        end else begin
                            stage     <= ST_DATA;
                            data_in_q <= dir_bit;
                            stat_in_q <= !dir_bit;
                            ping_q    <= hs_q && !dir_bit;
                        end
                    end else begin
                        irq_setup_err <= 1'b1;
                        stage         <= ST_IDLE;
                    end
                end else if (rsp == RSP_STALL) begin
                    irq_stall <= 1'b1;
                    stage     <= ST_IDLE;
                end else if (rsp == RSP_NAK) begin
                    if (!ping_q && hs_q && out_phase) ping_q <= 1'b1;
                end else if (ping_q) begin
                    ping_q <= 1'b0;
                end else if (stage == ST_STATUS) begin
                    irq_done <= 1'b1;
                    stage    <= ST_IDLE;
                end else begin
                    if ((data_in_q && in_last) || (!data_in_q && (rem_q == out_n))) begin
                        stage  <= ST_STATUS;
                        tog_q  <= 1'b1;
                        ping_q <= hs_q && !stat_in_q;
                    end else begin
                        tog_q <= !tog_q;
                    end
                    rem_q <= rem_q - (data_in_q ? in_n : out_n);
                end
            end
        end
    end
endmodule

// File: rtl/usb_ctl_seq.sv
module usb_ctl_seq
    import usbctl_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int MAX_TMO = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we_i,
    input  logic [1:0]  reg_sel_i,
    input  logic [15:0] reg_wdata_i,
    output logic [63:0] req_regs_o,
    input  logic [6:0]  dev_sel_i,
    input  logic        high_speed_i,
    input  logic        start_i,
    output logic        busy_o,
    output logic        pe_req_valid_o,
    output logic [1:0]  pe_token_o,
    output logic [6:0]  pe_addr_o,
    output logic        pe_toggle_o,
    output logic [15:0] pe_len_o,
    input  logic        pe_resp_valid_i,
    input  logic [1:0]  pe_resp_i,
    input  logic [15:0] pe_rx_len_i,
    output logic        irq_setup_ack_o,
    output logic        irq_setup_err_o,
    output logic        irq_stall_o,
    output logic        irq_err_o,
    output logic        irq_done_o
);
    ctl_req_t req;
    logic     in_setup, accept, is_tmo, tmo_hit;

    assign busy_o     = in_setup;
    assign req_regs_o = req;

    ctl_req_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we_i),
        .sel   (reg_sel_i),
        .wdata (reg_wdata_i),
        .lock  (in_setup),
        .req   (req)
    );

    ctl_retry_cnt #(.LIMIT(MAX_TMO)) u_tmo (
        .clk (clk),
        .rst (rst),
        .inc (accept && is_tmo),
        .clr ((accept && !is_tmo) || (start_i && !pe_req_valid_o)),
        .hit (tmo_hit)
    );

    ctl_stage_fsm #(.MAX_PKT(MAX_PKT)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start         (start_i),
        .dev_sel       (dev_sel_i),
        .high_speed    (high_speed_i),
        .dir_bit       (req.rtype[7]),
        .wlength       (req.wlength),
        .resp_valid    (pe_resp_valid_i),
        .resp          (pe_resp_i),
        .rx_len        (pe_rx_len_i),
        .tmo_hit       (tmo_hit),
        .accept        (accept),
        .is_tmo        (is_tmo),
        .in_setup      (in_setup),
        .req_valid     (pe_req_valid_o),
        .token         (pe_token_o),
        .addr          (pe_addr_o),
        .toggle        (pe_toggle_o),
        .len           (pe_len_o),
        .irq_setup_ack (irq_setup_ack_o),
        .irq_setup_err (irq_setup_err_o),
        .irq_stall     (irq_stall_o),
        .irq_err       (irq_err_o),
        .irq_done      (irq_done_o)
    );
endmodule

// File: rtl/usb_ctl_seq_chk.sv
module usb_ctl_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [63:0] req_regs_o,
    input logic        busy_o,
    input logic        pe_req_valid_o,
    input logic [1:0]  pe_token_o,
    input logic        pe_toggle_o,
    input logic [15:0] pe_len_o,
    input logic        irq_setup_ack_o,
    input logic        irq_setup_err_o,
    input logic        irq_stall_o,
    input logic        irq_err_o,
    input logic        irq_done_o
);
    assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (!pe_req_valid_o && start_i) |=> busy_o);

    assert_regs_locked_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (req_regs_o == $past(req_regs_o)));

    assert_setup_packet_R4: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (pe_token_o == 2'd0 && !pe_toggle_o && pe_len_o == 16'd8));

    assert_first_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_setup_ack_o && pe_req_valid_o) |-> pe_toggle_o);

    assert_setup_ack_R9: assert property (@(posedge clk) disable iff (rst)
        irq_setup_ack_o |-> ($past(busy_o) && !busy_o));

    assert_stall_idle_R10: assert property (@(posedge clk) disable iff (rst)
        irq_stall_o |-> !pe_req_valid_o);

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        irq_err_o |-> !pe_req_valid_o);

    assert_done_alone_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_setup_ack_o, irq_stall_o, irq_done_o, irq_setup_err_o}));
endmodule

bind usb_ctl_seq usb_ctl_seq_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .req_regs_o      (req_regs_o),
    .busy_o          (busy_o),
    .pe_req_valid_o  (pe_req_valid_o),
    .pe_token_o      (pe_token_o),
    .pe_toggle_o     (pe_toggle_o),
    .pe_len_o        (pe_len_o),
    .irq_setup_ack_o (irq_setup_ack_o),
    .irq_setup_err_o (irq_setup_err_o),
    .irq_stall_o     (irq_stall_o),
    .irq_err_o       (irq_err_o),
    .irq_done_o      (irq_done_o)
);

// File: tb/usb_ctl_seq_tb.sv
module usb_ctl_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_sel_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [63:0] req_regs_o;
    logic [6:0]  dev_sel_i = '0;
    logic        high_speed_i = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o;
    logic        pe_req_valid_o;
    logic [1:0]  pe_token_o;
    logic [6:0]  pe_addr_o;
    logic        pe_toggle_o;
    logic [15:0] pe_len_o;
    logic        pe_resp_valid_i = 1'b0;
    logic [1:0]  pe_resp_i = '0;
    logic [15:0] pe_rx_len_i = '0;
    logic        irq_setup_ack_o, irq_setup_err_o, irq_stall_o, irq_err_o, irq_done_o;

    always #2 clk = ~clk;

    usb_ctl_seq dut_i (.*);

    int vectors = 0;
    int errors  = 0;
    int q_rsp[$];
    int q_rx[$];

    // reference model state
    int m_state = 0;
    int m_tog = 0, m_ping = 0, m_din = 0, m_sin = 0, m_hs = 0, m_addr = 0, m_rem = 0, m_to = 0;
    int m_regs[4] = '{0, 0, 0, 0};
    int e_sack = 0, e_serr = 0, e_stall = 0, e_err = 0, e_done = 0;

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int exp_token();
        if (m_state == 1) return 0;
        if (m_state == 2) return m_din ? 1 : (m_ping ? 3 : 2);
        return m_sin ? 1 : (m_ping ? 3 : 2);
    endfunction

    function automatic int exp_len();
        if (m_state == 1) return 8;
        if (m_state == 2 && m_din) return 64;
        if (m_state == 2 && !m_ping) return imin(m_rem, 64);
        return 0;
    endfunction

    function automatic bit cur_out();
        return (m_state == 2 && !m_din) || (m_state == 3 && !m_sin);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare();
        int regs_exp;
        vectors++;
        chk(busy_o == (m_state == 1), "R1 busy", busy_o, m_state == 1);
        chk(pe_req_valid_o == (m_state != 0), "R6 valid", pe_req_valid_o, m_state != 0);
        for (int i = 0; i < 4; i++) begin
            regs_exp = m_regs[i];
            chk(req_regs_o[i*16 +: 16] == regs_exp[15:0], "R2 regs", req_regs_o[i*16 +: 16], regs_exp);
        end
        if (m_state != 0) begin
            chk(pe_token_o == exp_token(), "R8 token", pe_token_o, exp_token());
            chk(pe_addr_o == m_addr, "R3 addr", pe_addr_o, m_addr);
            chk(pe_toggle_o == m_tog, "R5 toggle", pe_toggle_o, m_tog);
            chk(pe_len_o == exp_len(), "R7 len", pe_len_o, exp_len());
        end
        chk(irq_setup_ack_o == e_sack, "R9 setup_ack", irq_setup_ack_o, e_sack);
        chk(irq_setup_err_o == e_serr, "R9 setup_err", irq_setup_err_o, e_serr);
        chk(irq_stall_o == e_stall, "R10 stall", irq_stall_o, e_stall);
        chk(irq_err_o == e_err, "R11 err", irq_err_o, e_err);
        chk(irq_done_o == e_done, "R12 done", irq_done_o, e_done);
    endtask

    task automatic model_step();
        int rsp, rx, n;
        bit fin;
        e_sack = 0; e_serr = 0; e_stall = 0; e_err = 0; e_done = 0;
        if (reg_we_i && m_state != 1) m_regs[reg_sel_i] = reg_wdata_i;
        if (m_state == 0) begin
            if (start_i) begin
                m_state = 1; m_tog = 0; m_ping = 0; m_to = 0;
                m_addr = dev_sel_i; m_hs = high_speed_i;
            end
        end else if (pe_resp_valid_i) begin
            rsp = pe_resp_i;
            rx  = pe_rx_len_i;
            if (rsp == 3) begin
                m_to++;
                if (m_to == 3) begin
                    e_err = 1;
                    if (m_state == 1) e_serr = 1;
                    m_state = 0;
                    m_to = 0;
                end
            end else begin
                m_to = 0;
                if (m_state == 1) begin
                    if (rsp == 0) begin
                        e_sack = 1;
                        m_tog = 1;
                        m_rem = m_regs[3];
                        if (m_rem == 0) begin
                            m_state = 3; m_sin = 1; m_ping = 0;
                        end else begin
                            m_state = 2;
                            m_din = (m_regs[0] >> 7) & 1;
                            m_sin = !m_din;
                            m_ping = m_hs && !m_din;
                        end
                    end else begin
                        e_serr = 1;
                        m_state = 0;
                    end
                end else if (rsp == 2) begin
                    e_stall = 1;
                    m_state = 0;
                end else if (rsp == 1) begin
                    if (!m_ping && m_hs && cur_out()) m_ping = 1;
                end else if (m_ping) begin
                    m_ping = 0;
                end else if (m_state == 3) begin
                    e_done = 1;
                    m_state = 0;
                end else begin
                    if (m_din) begin
                        n = imin(rx, m_rem);
                        fin = (rx < 64) || (rx >= m_rem);
                    end else begin
                        n = imin(m_rem, 64);
                        fin = (n == m_rem);
                    end
                    m_rem -= n;
                    if (fin) begin
                        m_state = 3; m_tog = 1; m_ping = m_hs && !m_sin;
                    end else begin
                        m_tog ^= 1;
                    end
                end
            end
        end
    endtask

    // one clock: respond from queue, advance model, clock, compare
    task automatic tick();
        if (pe_req_valid_o && q_rsp.size() > 0) begin
            pe_resp_valid_i = 1'b1;
            pe_resp_i       = 2'(q_rsp.pop_front());
            pe_rx_len_i     = 16'(q_rx.pop_front());
        end else begin
            pe_resp_valid_i = 1'b0;
            pe_resp_i       = '0;
            pe_rx_len_i     = '0;
        end
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        reg_we_i = 1'b0;
        start_i  = 1'b0;
        pe_resp_valid_i = 1'b0;
    endtask

    task automatic wr(input int sel, input int val);
        reg_we_i = 1'b1; reg_sel_i = 2'(sel); reg_wdata_i = 16'(val);
        tick();
    endtask

    task automatic push(input int r, input int rx);
        q_rsp.push_back(r);
        q_rx.push_back(rx);
    endtask

    task automatic load(input int rtype, input int length);
        wr(0, rtype); wr(1, 16'h0100); wr(2, 0); wr(3, length);
    endtask

    task automatic go(input int addr, input bit hs);
        dev_sel_i = 7'(addr); high_speed_i = hs; start_i = 1'b1;
        tick();
        dev_sel_i = '0;
    endtask

    task automatic drain();
        int n = 0;
        while ((m_state != 0 || q_rsp.size() > 0) && n < 300) begin
            tick();
            n++;
        end
        if (n >= 300) chk(0, "R12 transfer hung", m_state, 0);
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare();  // reset state R1 R2

        // R6 R5 full-speed control read, short IN, status OUT without PING
        load(16'h0680, 18);
        push(0, 0); push(1, 0); push(0, 18); push(0, 0);
        go(5, 0); drain();

        // R8 R7 high-speed control write of 100 bytes with NAKs
        load(16'h0900, 100);
        push(0, 0); push(1, 0); push(0, 0); push(1, 0); push(0, 0);
        push(0, 0); push(0, 0); push(0, 0);
        go(9, 1); drain();

        // R8 high-speed read, status OUT preceded by PING
        load(16'h0680, 18);
        push(0, 0); push(0, 18); push(0, 0); push(0, 0);
        go(12, 1); drain();

        // R6 no-data request, status IN
        load(16'h0500, 0);
        push(0, 0); push(0, 0);
        go(3, 1); drain();

        // R7 exact multiple read 128 bytes, then early short packet
        load(16'h0680, 128);
        push(0, 0); push(0, 64); push(0, 64); push(0, 0);
        go(20, 0); drain();
        load(16'h0680, 100);
        push(0, 0); push(0, 10); push(0, 0);
        go(21, 0); drain();

        // R2 R1 writes and start while busy are ignored
        load(16'h0500, 0);
        go(7, 0);
        wr(3, 16'h0055); wr(0, 16'h00ff);
        start_i = 1'b1; dev_sel_i = 7'd99; tick();
        push(0, 0); push(0, 0);
        drain();

        // R9 setup NAK and setup STALL
        push(1, 0); go(4, 0); drain();
        push(2, 0); go(4, 0); drain();

        // R10 STALL in data stage
        load(16'h0680, 40);
        push(0, 0); push(2, 0);
        go(6, 0); drain();

        // R11 two timeouts then ACK recovers, then three timeouts end
        load(16'h0500, 0);
        push(0, 0); push(3, 0); push(3, 0); push(0, 0);
        go(8, 0); drain();
        push(0, 0); push(3, 0); push(3, 0); push(3, 0);
        go(8, 0); drain();
        push(3, 0); push(3, 0); push(3, 0);
        go(8, 0); drain();

        // R5 timeout retry on IN keeps toggle, then STALL in status R10
        load(16'h0680, 200);
        push(0, 0); push(0, 64); push(3, 0); push(0, 64); push(0, 5); push(2, 0);
        go(30, 0); drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule